// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a bank of general-purpose input pins and records selected signal transitions as interrupt events. Each pin has one enable bit for low-to-high transitions and one for high-to-low transitions. Both bits may be set, and then the pin catches either direction. A detected transition sets a sticky status bit. Software clears that bit by writing a one to it. Inputs first pass through a synchronizer. A transition is found by comparing the synchronized level with the level registered one cycle earlier.

The low pins, 0 through 10, each drive their own interrupt line. The remaining pins, 11 through 27, are merged into one summary line, and an interrupt handler reads the status word to find which of them fired. A separate wake-enable register has one bit for each pin and one extra bit for a real-time-clock alarm input. Any enabled source that is active raises a wakeup request. Software reaches the block through a small word-addressed register bus: address, write data, write strobe and combinational read data.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads zero and `irq_direct`, `irq_summary` and `wake_req` are low.
- R2: When bit i of the rising-enable register (address 0) is set, a 0-to-1 change on `pins_in[i]` sets bit i of the status register (address 2).
- R3: When bit i of the falling-enable register (address 1) is set, a 1-to-0 change on `pins_in[i]` sets status bit i. A rising change on a pin enabled only for falling edges leaves its status bit clear.
- R4: A pin with both enable bits set records both directions. A pin with neither enable bit set never sets its status bit.
- R5: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A set status bit otherwise stays set.
- R6: When a new edge on a pin is detected in the same cycle as a write of 1 to that pin's status bit, the bit stays set.
- R7: `irq_direct[i]` equals status bit i for pins 0 to 10.
- R8: `irq_summary` is high exactly when any of status bits 11 to 27 is set. Status bits 0 to 10 do not affect it.
- R9: The wake register (address 3) holds bit i for pin i and bit 28 for the clock alarm. `wake_req` is high when some pin's wake bit and status bit are both set, or when bit 28 is set and `rtc_alarm_in` is high.
- R10: Every register reads back its contents. Bits 28 to 31 of the enable and status registers, and bits 29 to 31 of the wake register, read as zero.
- R11: A pin change made between clock edges appears in the status register after the third rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pins_in | input | 28 | Asynchronous pin levels |
| rtc_alarm_in | input | 1 | Clock alarm wake source |
| irq_direct | output | 11 | Interrupt lines for pins 0 to 10 |
| irq_summary | output | 1 | Merged interrupt for pins 11 to 27 |
| wake_req | output | 1 | Wakeup request |

## Verification
The hardest case to reach is a clearing write that lands in the exact cycle a fresh edge is detected on the same pin. Detection trails the pin change by the synchronizer and the previous-level register. The bench therefore changes a pin at a falling clock edge, waits two full cycles, and presents the clearing write so that it commits on the third rising edge, which is also the edge that sets the bit. It then reads the status register to confirm that the new event survived. A second, ordinary clear follows to show that the write path itself still works.

// File: rtl/gedi_pkg.sv
package gedi_pkg;
   localparam int unsigned REG_AW    = 2;
   localparam logic [REG_AW-1:0] A_RISE = 2'd0;
   localparam logic [REG_AW-1:0] A_FALL = 2'd1;
   localparam logic [REG_AW-1:0] A_STAT = 2'd2;
   localparam logic [REG_AW-1:0] A_WAKE = 2'd3;
endpackage

// File: rtl/gedi_sync.sv
module gedi_sync #(
   parameter int unsigned WIDTH  = 28,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gedi_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[0] <= '0;
               else        stg_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gedi_edge_status.sv
module gedi_edge_status #(
   parameter int unsigned WIDTH = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic [WIDTH-1:0] rise_en_i,
   input  logic [WIDTH-1:0] fall_en_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] det_o,
   output logic [WIDTH-1:0] sts_o
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] sts_q;
   logic [WIDTH-1:0] up_w;
   logic [WIDTH-1:0] down_w;

   assign up_w   = lvl_i & ~prev_q;
   assign down_w = ~lvl_i & prev_q;
   assign det_o  = (up_w & rise_en_i) | (down_w & fall_en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         sts_q  <= '0;
      end else begin
         prev_q <= lvl_i;
         sts_q  <= det_o | (sts_q & ~clr_i);
      end
   end

   assign sts_o = sts_q;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_chk
         AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            det_o[i] |=> sts_q[i]); // R6
         AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[i] && !clr_i[i]) |=> sts_q[i]); // R5
         AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !det_o[i]) |=> !sts_q[i]); // R5
         AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!rise_en_i[i] && !fall_en_i[i] && !sts_q[i]) |=> !sts_q[i]); // R4
      end
   endgenerate
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
   import gedi_pkg::*;
#(
   parameter int unsigned NPINS   = 28,
   parameter int unsigned NDIRECT = 11,
   parameter int unsigned DW      = 32,
   parameter int unsigned SYNC_N  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REG_AW-1:0]   bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   input  logic                bus_we,
   output logic [DW-1:0]       bus_rdata,
   input  logic [NPINS-1:0]    pins_in,
   input  logic                rtc_alarm_in,
   output logic [NDIRECT-1:0]  irq_direct,
   output logic                irq_summary,
   output logic                wake_req
);
   localparam int unsigned WAKE_W = NPINS + 1;
   localparam int unsigned NHIGH  = NPINS - NDIRECT;

   generate
      if (NDIRECT >= NPINS) begin : g_bad_split
         $error("gpio_edge_irq: NDIRECT must be below NPINS");
      end
      if (WAKE_W > DW) begin : g_bad_width
         $error("gpio_edge_irq: NPINS+1 must fit in DW");
      end
   endgenerate

   logic [NPINS-1:0]  rise_q, fall_q, lvl_w, det_w, sts_w, clr_w;
   logic [WAKE_W-1:0] wake_q;
   logic              wr_rise, wr_fall, wr_stat, wr_wake;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata[DW-1:WAKE_W];

   assign wr_rise = bus_we && (bus_addr == A_RISE);
   assign wr_fall = bus_we && (bus_addr == A_FALL);
   assign wr_stat = bus_we && (bus_addr == A_STAT);
   assign wr_wake = bus_we && (bus_addr == A_WAKE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q <= '0;
         fall_q <= '0;
         wake_q <= '0;
      end else begin
         if (wr_rise) rise_q <= bus_wdata[NPINS-1:0];
         if (wr_fall) fall_q <= bus_wdata[NPINS-1:0];
         if (wr_wake) wake_q <= bus_wdata[WAKE_W-1:0];
      end
   end

   assign clr_w = wr_stat ? bus_wdata[NPINS-1:0] : '0;

   gedi_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_in),
      .q_o   (lvl_w)
   );

   gedi_edge_status #(.WIDTH(NPINS)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_i     (lvl_w),
      .rise_en_i (rise_q),
      .fall_en_i (fall_q),
      .clr_i     (clr_w),
      .det_o     (det_w),
      .sts_o     (sts_w)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_RISE:  bus_rdata[NPINS-1:0]  = rise_q;
         A_FALL:  bus_rdata[NPINS-1:0]  = fall_q;
         A_STAT:  bus_rdata[NPINS-1:0]  = sts_w;
         default: bus_rdata[WAKE_W-1:0] = wake_q;
      endcase
   end

   assign irq_direct  = sts_w[NDIRECT-1:0];
   assign irq_summary = |sts_w[NPINS-1:NDIRECT];
   assign wake_req    = (|(wake_q[NPINS-1:0] & sts_w)) | (wake_q[NPINS] & rtc_alarm_in);

   AST_SUMMARY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && (&bus_wdata[NPINS-1:NDIRECT]) && !(|det_w[NPINS-1:NDIRECT]))
      |=> !irq_summary); // R8
   AST_SUMMARY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (|det_w[NPINS-1:NDIRECT]) |=> irq_summary); // R8
   AST_WAKE_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_q[NPINS] && rtc_alarm_in) |-> wake_req); // R9
   AST_DIRECT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq_direct) <= $countones(sts_w)); // R7

   initial begin
      AST_HIGH_GROUP: assert (NHIGH > 0); // R8
   end
endmodule

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;
   localparam int NP = 28;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pins = '0;
   logic        rtc = 1'b0;
   logic [10:0] irq_direct;
   logic        irq_summary;
   logic        wake_req;
   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   gpio_edge_irq dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .pins_in(pins),
      .rtc_alarm_in(rtc), .irq_direct(irq_direct), .irq_summary(irq_summary),
      .wake_req(wake_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      tick(1);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic quiet();
      wr(2'd0, 0); wr(2'd1, 0); wr(2'd3, 0);
      pins = '0; rtc = 1'b0;
      tick(4);
      wr(2'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v); chk("R1 reg", v, 0);
      end
      chk("R1 outs", {irq_direct, irq_summary, wake_req}, 0);
   endtask

   task automatic t_latency();
      logic [31:0] v;
      quiet();
      wr(2'd0, 32'h8);
      pins[3] = 1'b1;
      tick(2);
      rd(2'd2, v); chk("R11 early", v, 0);
      tick(1);
      rd(2'd2, v); chk("R11 R2 set", v, 32'h8);
      chk("R7 direct3", {21'd0, irq_direct}, 32'h8);
      wr(2'd2, 32'h8);
      rd(2'd2, v); chk("R5 clear", v, 0);
      chk("R7 direct low", {21'd0, irq_direct}, 0);
   endtask

   task automatic t_fall();
      logic [31:0] v;
      quiet();
      wr(2'd1, 32'h1 << 20);
      pins[20] = 1'b1; tick(4);
      rd(2'd2, v); chk("R3 rise ignored", v, 0);
      pins[20] = 1'b0; tick(4);
      rd(2'd2, v); chk("R3 fall set", v, 32'h1 << 20);
      chk("R8 summary on", {31'd0, irq_summary}, 1);
      wr(2'd2, 32'h1 << 20);
      chk("R8 summary off", {31'd0, irq_summary}, 0);
   endtask

   task automatic t_both_none();
      logic [31:0] v;
      quiet();
      wr(2'd0, 32'h20); wr(2'd1, 32'h20);
      pins[5] = 1'b1; tick(4);
      rd(2'd2, v); chk("R4 both up", v, 32'h20);
      wr(2'd2, 32'h20);
      pins[5] = 1'b0; tick(4);
      rd(2'd2, v); chk("R4 both down", v, 32'h20);
      wr(2'd2, 32'h20);
      pins[6] = 1'b1; tick(4);
      pins[6] = 1'b0; tick(4);
      rd(2'd2, v); chk("R4 none", v, 0);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      quiet();
      wr(2'd0, 32'h1020);
      pins[5] = 1'b1; pins[12] = 1'b1; tick(4);
      rd(2'd2, v); chk("R5 both set", v, 32'h1020);
      wr(2'd2, 32'h0);
      rd(2'd2, v); chk("R5 zero write", v, 32'h1020);
      wr(2'd2, 32'h1000);
      rd(2'd2, v); chk("R5 partial", v, 32'h20);
      chk("R8 low only", {31'd0, irq_summary}, 0);
      chk("R7 direct5", {21'd0, irq_direct}, 32'h20);
   endtask

   task automatic t_summary();
      logic [31:0] v;
      quiet();
      wr(2'd0, (32'h1 << 11) | (32'h1 << 27));
      pins[11] = 1'b1; pins[27] = 1'b1; tick(4);
      chk("R8 two high", {31'd0, irq_summary}, 1);
      chk("R7 no direct", {21'd0, irq_direct}, 0);
      wr(2'd2, 32'h1 << 11);
      chk("R8 one left", {31'd0, irq_summary}, 1);
      wr(2'd2, 32'h1 << 27);
      chk("R8 none left", {31'd0, irq_summary}, 0);
      rd(2'd2, v); chk("R8 status", v, 0);
   endtask

   task automatic t_race();
      logic [31:0] v;
      quiet();
      wr(2'd0, 32'h100); wr(2'd1, 32'h100);
      pins[8] = 1'b1; tick(4);
      rd(2'd2, v); chk("R6 pre", v, 32'h100);
      pins[8] = 1'b0;
      tick(2);
      wr(2'd2, 32'h100);
      rd(2'd2, v); chk("R6 edge wins", v, 32'h100);
      wr(2'd2, 32'h100);
      rd(2'd2, v); chk("R6 later clear", v, 0);
   endtask

   task automatic t_wake();
      logic [31:0] v;
      quiet();
      wr(2'd3, (32'h1 << 28) | 32'h4);
      rd(2'd3, v); chk("R10 wake rb", v, 32'h1000_0004);
      rtc = 1'b1; #1;
      chk("R9 alarm", {31'd0, wake_req}, 1);
      rtc = 1'b0; #1;
      chk("R9 alarm off", {31'd0, wake_req}, 0);
      wr(2'd0, 32'h204);
      pins[9] = 1'b1; tick(4);
      chk("R9 unwoken pin", {31'd0, wake_req}, 0);
      pins[2] = 1'b1; tick(4);
      chk("R9 pin wake", {31'd0, wake_req}, 1);
      wr(2'd2, 32'h4);
      chk("R9 cleared", {31'd0, wake_req}, 0);
   endtask

   task automatic t_readback();
      logic [31:0] v;
      quiet();
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R10 rise", v, 32'h0FFF_FFFF);
      wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R10 fall", v, 32'h0FFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R10 wake", v, 32'h1FFF_FFFF);
      wr(2'd0, 32'h0123_4567); rd(2'd0, v); chk("R10 pattern", v, 32'h0123_4567);
      wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R10 status", v, 0);
   endtask

   initial begin
      #(200000 * 20);
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_latency();
      t_fall();
      t_both_none();
      t_w1c();
      t_summary();
      t_race();
      t_wake();
      t_readback();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule